// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns a frame body into a complete wire frame. The body is the destination address, the source address, type/length and payload. It arrives one byte per transfer on a valid/ready stream, with a last marker on its final byte. The frame leaves on a byte-wide output that carries a valid flag and a last flag, and the output cannot be stalled.

When a body starts, the block sends a preamble and a start delimiter while it holds the input off. It then passes the body bytes through in order. If the body is shorter than the minimum, it appends zero bytes. Last, it appends a 32-bit frame check sequence that covers the body and any padding.

A body that grows beyond the longest legal size is cut short. Nothing more of it is sent, no last flag is raised, and an error pulse is given. The rest of that body is drained from the input so that the next body starts clean.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_last`, `err_long` and `in_ready` are all low.
- R2: A frame starts when `in_valid` is seen while the block is idle. It begins with seven 0x55 bytes and then one 0xD5 byte. These are byte values whose bits go to the medium least significant bit first.
- R3: `in_ready` stays low for exactly 8 cycles from the start of a frame, which is the whole preamble. It also stays low while padding and check bytes are being sent.
- R4: Body bytes appear on `out_data`, with `out_valid` high, in the order they were accepted. Input gaps only insert cycles with `out_valid` low.
- R5: A body shorter than 60 bytes is followed by 0x00 bytes until body plus padding total exactly 60 bytes. A body of 60 bytes or more gets no padding.
- R6: After the body and padding come 4 check bytes. The check value is a CRC-32 with reflected polynomial 0xEDB88320, a start value of all ones and a final inversion, computed over body and padding. Its least significant byte is sent first, and `out_last` is high on the fourth check byte only.
- R7: The frame from the first body byte through the last check byte is between 64 and 1518 bytes long.
- R8: If a body reaches a 1515th byte (a payload over 1500 bytes), that byte and all later bytes up to `in_last` are accepted and discarded, and nothing more is sent. `out_last` is not raised for that frame, and `err_long` pulses high for one cycle in the cycle after the 1515th byte is accepted. The next body is framed normally.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Body byte |
| in_valid | input | 1 | Body byte present |
| in_last | input | 1 | Final byte of the body |
| in_ready | output | 1 | Block accepts a body byte this cycle |
| out_data | output | 8 | Wire frame byte |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_last | output | 1 | Final byte of the frame |
| err_long | output | 1 | One-cycle pulse: body too long, frame abandoned |

## Verification
Two decisions can fall in the same cycle. One is taking the final body byte. The other is choosing between padding and going straight to the check bytes, and the last byte can also be the one that crosses the length limit. The bench provokes this with bodies of 59, 60 and 61 bytes, with and without input gaps. It also sends a 1514-byte body and an over-long body. Each frame is judged against a full expected byte image built in the bench, including the check value.

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int MAX_BODY = 1514
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  output logic       err_long
);
  localparam int CW = $clog2(MAX_BODY + 2);
  localparam int IW = $clog2(PRE_LEN + 2);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_BODY);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BODY);
  localparam logic [IW-1:0] PRE_I = IW'(PRE_LEN);
  localparam logic [IW-1:0] FCS_I = IW'(3);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_BODY, S_PAD, S_FCS, S_DROP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [31:0]   crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign in_ready = (st == S_BODY) || (st == S_DROP);

  wire              take   = in_valid && in_ready;
  wire [CW-1:0]     cnt_nx = cnt + 1'b1;
  wire [31:0]       fcs    = ~crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      idx       <= '0;
      crc       <= '1;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      err_long  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      err_long  <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          st        <= S_PRE;
          out_data  <= 8'h55;
          out_valid <= 1'b1;
          idx       <= IW'(1);
          cnt       <= '0;
          crc       <= '1;
        end
        S_PRE: begin
          out_valid <= 1'b1;
          out_data  <= (idx == PRE_I) ? 8'hD5 : 8'h55;
          idx       <= idx + 1'b1;
          if (idx == PRE_I) st <= S_BODY;
        end
        S_BODY: if (take) begin
          if (cnt == MAX_C) begin
            err_long <= 1'b1;
            st       <= in_last ? S_IDLE : S_DROP;
          end else begin
            out_data  <= in_data;
            out_valid <= 1'b1;
            crc       <= crc_step(crc, in_data);
            cnt       <= cnt_nx;
            idx       <= '0;
            if (in_last) st <= (cnt_nx < MIN_C) ? S_PAD : S_FCS;
          end
        end
        S_PAD: begin
          out_data  <= 8'h00;
          out_valid <= 1'b1;
          crc       <= crc_step(crc, 8'h00);
          cnt       <= cnt_nx;
          if (cnt_nx == MIN_C) st <= S_FCS;
        end
        S_FCS: begin
          out_data  <= fcs[8*idx[1:0] +: 8];
          out_valid <= 1'b1;
          idx       <= idx + 1'b1;
          if (idx == FCS_I) begin
            out_last <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_DROP: if (take && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R7
  frame_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (cnt >= MIN_C && cnt <= MAX_C));

  // R8
  abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_long |-> !out_valid && !out_last);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_long |=> !err_long);

  // R3
  ready_not_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_last);
endmodule

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, out_valid, out_last, err_long;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  eth_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .err_long(err_long)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned cap[$];
  byte unsigned body[$];
  bit seen_last, after_body;
  int last_cnt, err_cnt, rdy_late;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      cap.push_back(out_data);
      if (out_last) begin seen_last = 1; last_cnt++; end
    end
    if (err_long) err_cnt++;
    if (after_body && in_ready && !seen_last) rdy_late++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit [31:0] ref_crc(input byte unsigned q[$]);
    bit [31:0] c = 32'hFFFFFFFF;
    foreach (q[k]) begin
      c ^= {24'h0, q[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send(input int len, input int gap_pct, output int lat);
    bit first = 1;
    lat = 0;
    body.delete();
    for (int i = 0; i < len; i++) body.push_back(8'($urandom));
    for (int i = 0; i < len; i++) begin
      if (i > 0 && $urandom_range(99) < gap_pct) begin
        in_valid = 0; in_last = 0;
        @(negedge clk);
      end
      in_data = body[i]; in_valid = 1; in_last = (i == len - 1);
      while (!in_ready) begin
        if (first) lat++;
        @(negedge clk);
      end
      first = 0;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    after_body = 1;
  endtask

  task automatic run_frame(input int len, input int gap_pct);
    byte unsigned exp[$];
    byte unsigned cov[$];
    bit [31:0] f;
    int lat, n, bad_pre, bad_body, bad_pad, bad_fcs, blen;
    cap.delete(); seen_last = 0; after_body = 0; rdy_late = 0; last_cnt = 0;
    send(len, gap_pct, lat);
    n = 0;
    while (!seen_last && n < 400) begin @(negedge clk); n++; end
    blen = (len < 60) ? 60 : len;
    foreach (body[k]) cov.push_back(body[k]);
    while (cov.size() < blen) cov.push_back(8'h00);
    f = ref_crc(cov);
    for (int k = 0; k < 7; k++) exp.push_back(8'h55);
    exp.push_back(8'hD5);
    foreach (cov[k]) exp.push_back(cov[k]);
    for (int k = 0; k < 4; k++) exp.push_back(f[8*k +: 8]);
    bad_pre = 0; bad_body = 0; bad_pad = 0; bad_fcs = 0;
    for (int k = 0; k < exp.size() && k < cap.size(); k++) begin
      if (cap[k] != exp[k]) begin
        if (k < 8) bad_pre++;
        else if (k < 8 + len) bad_body++;
        else if (k < 8 + blen) bad_pad++;
        else bad_fcs++;
      end
    end
    chk(lat == 8, "R3 ready low through preamble", lat, 8);
    chk(cap.size() == exp.size(), "R7 frame byte count", cap.size(), exp.size());
    chk(bad_pre == 0, "R2 preamble and delimiter", bad_pre, 0);
    chk(bad_body == 0, "R4 body bytes in order", bad_body, 0);
    chk(bad_pad == 0, "R5 zero padding to 60", bad_pad, 0);
    chk(bad_fcs == 0, "R6 check bytes", bad_fcs, 0);
    chk(last_cnt == 1, "R6 single out_last", last_cnt, 1);
    chk(rdy_late == 0, "R3 ready low in pad and check", rdy_late, 0);
  endtask

  task automatic run_long(input int len);
    int lat, bad;
    cap.delete(); seen_last = 0; after_body = 0; last_cnt = 0; err_cnt = 0;
    send(len, 0, lat);
    repeat (6) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 1514 && k + 8 < cap.size(); k++)
      if (cap[k + 8] != body[k]) bad++;
    chk(err_cnt == 1, "R8 error pulse", err_cnt, 1);
    chk(cap.size() == 8 + 1514, "R8 output stops at limit", cap.size(), 8 + 1514);
    chk(last_cnt == 0, "R8 no out_last", last_cnt, 0);
    chk(bad == 0, "R4 bytes before abort", bad, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9127));
    in_valid = 1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_last && !err_long && !in_ready, "R1 outputs in reset",
        {out_valid, out_last, err_long, in_ready}, 0);
    in_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !out_last && !err_long && !in_ready, "R1 outputs after reset",
        {out_valid, out_last, err_long, in_ready}, 0);
    run_frame(1, 0);
    run_frame(59, 0);
    run_frame(60, 0);
    run_frame(61, 0);
    run_frame(59, 40);
    run_frame(60, 40);
    run_frame(61, 40);
    run_frame(14, 20);
    for (int t = 0; t < 20; t++) run_frame($urandom_range(120, 1), $urandom_range(50));
    run_frame(1514, 0);
    run_long(1515);
    run_frame(45, 10);
    run_long(1520);
    run_frame(70, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule